// File: doc/BRIEF.md
# Interrupt Coalescing Delay Timer

This block sits in a DMA channel between the completion path and the channel's interrupt line. Each completion that asks for an interrupt raises a one-cycle request. With a nonzero delay programmed, the first request opens a timing window of whole microseconds. Requests that arrive inside the window are merged into it, and one interrupt is raised when the window closes. With a zero delay, each request raises the interrupt at once. The interrupt is a level that stays high until software acknowledges it.

Software sees one 16-bit control word through a plain address, write-strobe and read-data port.
- Bits 13:0 hold the window length in microseconds, from 1 to 16383.
- Bit 14 always reads zero.
- Bit 15 is a fixed capability flag that reads one.

A free-running divider turns the core clock into a one-cycle microsecond tick, and the window counts these ticks. The control machine has three states:
- **Idle**: no window is open and the interrupt is low.
- **Count**: a window is open and counting ticks.
- **Fire**: the interrupt is asserted and waits for acknowledge.

The transitions are:
- *start* (Idle to Count): a request arrives with a nonzero delay.
- *direct* (Idle to Fire): a request arrives with a zero delay.
- *expire* (Count to Fire): the last tick of the window.
- *release* (Fire to Idle): acknowledge with nothing carried.
- *rearm* (Fire to Count): acknowledge with a carried request and a nonzero delay.
- *refire* (Fire to Fire): acknowledge with a carried request and a zero delay.

Top module: `irq_coalesce_ctl`

## Requirements
- R1: After synchronous reset the control word at byte address 0x0C reads 0x8000 (capability bit 15 set, period zero) and the interrupt output is low.
- R2: A write to address 0x0C stores write-data bits 13:0 as the period. The word reads back as {1, 0, period}. Bits 15 and 14 of the write data have no effect.
- R3: A write to any address other than 0x0C leaves the period unchanged, and a read of any other address returns zero.
- R4: With period zero, a request sampled at clock edge k in Idle sets the interrupt output high right after edge k.
- R5: Number the edges after reset release 1, 2, 3, and so on. The tick is active in the cycle before edge j when j is a multiple of CYC_PER_US. For a request sampled at edge k in Idle with period N > 0, the interrupt rises after the N-th tick edge strictly later than k, which is edge (floor(k/C)+1)*C + (N-1)*C.
- R6: Requests that arrive while a window is counting neither restart nor extend it. The whole window produces exactly one rising edge of the interrupt.
- R7: The interrupt stays high until an acknowledge is sampled while it is high. Acknowledge with nothing carried lowers it right after that edge. Acknowledge while the interrupt is low has no effect.
- R8: A request sampled while the interrupt is high, or together with the acknowledge, is carried. On acknowledge with a carried request and period N > 0, the interrupt drops and a new window starts at the acknowledge edge with the R5 timing. With period zero, the interrupt stays high.
- R9: Rewriting the period while a window counts does not change that window. The next window uses the new value.
- R10: The largest period, 0x3FFF, is stored and timed exactly as R5 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Read data for reg_addr (combinational) |
| cmpl_irq_req | input | 1 | One-cycle completion with interrupt request |
| irq_ack | input | 1 | Acknowledge that clears the interrupt |
| irq_out | output | 1 | Level interrupt output |

## Verification
The hardest case to reach is the carried request. A request must land while the interrupt is already high and waiting, and the acknowledge that follows must then start a fresh window timed from the acknowledge edge, not from the request. The bench waits for the interrupt to rise, injects a request, acknowledges, and pushes the expected rising edge for the new window into its scoreboard queue. A variant of the same sequence with a zero period checks that the output never drops across the acknowledge. A second hard case is a period rewrite in the middle of a window. It is driven a few cycles after the window opens, and the scoreboard expects the fire edge computed from the old value.

// File: rtl/coal_pkg.sv
`timescale 1ns/1ps
package coal_pkg;
    localparam int PERIOD_W = 14;
    localparam int REG_W    = 16;
    localparam int CAP_BIT  = 15;
    localparam int RSV_BIT  = 14;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_COUNT = 2'd1,
        CS_FIRE  = 2'd2
    } coal_state_e;
endpackage

// File: rtl/coal_tick_div.sv
`timescale 1ns/1ps
module coal_tick_div #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CYC_PER_US > 1) begin : g_div
            localparam int CW = $clog2(CYC_PER_US);
            localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);
            logic [CW-1:0] div_cnt;

            always_ff @(posedge clk) begin
                if (rst)
                    div_cnt <= '0;
                else if (div_cnt == LAST)
                    div_cnt <= '0;
                else
                    div_cnt <= div_cnt + 1'b1;
            end

            assign tick = (div_cnt == LAST);

            // R5: the tick lasts one cycle and is never back to back
            p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/coal_delay_reg.sv
`timescale 1ns/1ps
module coal_delay_reg
    import coal_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h0C,
    parameter bit              CAP_PRESENT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic [PERIOD_W-1:0] period
);
    logic sel;
    logic [REG_W-1:0] word;

    assign sel = (addr == REG_OFFSET);

    generate
        if (CAP_PRESENT) begin : g_store
            logic [PERIOD_W-1:0] period_q;
            always_ff @(posedge clk) begin
                if (rst)
                    period_q <= '0;
                else if (sel && wr_en)
                    period_q <= wr_data[PERIOD_W-1:0];
            end
            assign period = period_q;
        end else begin : g_absent
            assign period = '0;
        end
    endgenerate

    always_comb begin
        word                    = '0;
        word[PERIOD_W-1:0]      = period;
        word[RSV_BIT]           = 1'b0;
        word[CAP_BIT]           = CAP_PRESENT;
        rd_data                 = sel ? word : '0;
    end

    // R2: the reserved bit never reads as one
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[RSV_BIT] == 1'b0);

    // R2: an accepted write shows up as the period on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en && CAP_PRESENT) |=> (period == $past(wr_data[PERIOD_W-1:0])));

    // R3: with no write to this word the period holds
    p_hold_period_r3: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr_en) |=> $stable(period));

    // R3: other addresses read zero
    p_other_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (rd_data == '0));
endmodule

// File: rtl/coal_window_fsm.sv
`timescale 1ns/1ps
module coal_window_fsm
    import coal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                req,
    input  logic                ack,
    input  logic [PERIOD_W-1:0] period,
    output logic                irq
);
    coal_state_e         st, st_nxt;
    logic [PERIOD_W-1:0] cnt;
    logic                carry;
    logic                zero_period;
    logic                has_more;
    logic                load_cnt;
    logic                last_tick;

    assign zero_period = (period == '0);
    assign has_more    = carry || req;
    assign last_tick   = tick && (cnt == PERIOD_W'(1));

    // next-state logic
    always_comb begin
        st_nxt   = st;
        load_cnt = 1'b0;
        unique case (st)
            CS_IDLE: begin
                if (req) begin
                    if (zero_period) begin
                        st_nxt = CS_FIRE;             // direct
                    end else begin
                        st_nxt   = CS_COUNT;          // start
                        load_cnt = 1'b1;
                    end
                end
            end
            CS_COUNT: begin
                if (last_tick)
                    st_nxt = CS_FIRE;                 // expire
            end
            CS_FIRE: begin
                if (ack) begin
                    if (!has_more) begin
                        st_nxt = CS_IDLE;             // release
                    end else if (zero_period) begin
                        st_nxt = CS_FIRE;             // refire
                    end else begin
                        st_nxt   = CS_COUNT;          // rearm
                        load_cnt = 1'b1;
                    end
                end
            end
            default: st_nxt = CS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            st <= CS_IDLE;
        else
            st <= st_nxt;
    end

    // window countdown
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_cnt)
            cnt <= period;
        else if (st == CS_COUNT && tick)
            cnt <= cnt - 1'b1;
    end

    // request carried across a pending interrupt
    always_ff @(posedge clk) begin
        if (rst)
            carry <= 1'b0;
        else if (st == CS_FIRE) begin
            if (ack)
                carry <= 1'b0;
            else if (req)
                carry <= 1'b1;
        end else
            carry <= 1'b0;
    end

    // outputs
    always_comb begin
        irq = (st == CS_FIRE);
    end

    // R4: zero period sends a request straight to the interrupt
    p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        (st == CS_IDLE && req && zero_period) |=> irq);

    // R5: an open window always has ticks left to count
    p_cnt_live_r5: assert property (@(posedge clk) disable iff (rst)
        (st == CS_COUNT) |-> (cnt != '0));

    // R5: no fire before the last tick
    p_no_early_r5: assert property (@(posedge clk) disable iff (rst)
        (st == CS_COUNT && !last_tick) |=> (st == CS_COUNT));

    // R6: a request during a window does not reload the count
    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (st == CS_COUNT && req && !tick) |=> (cnt == $past(cnt)));

    // R7: the interrupt holds until acknowledged
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);

    // R7: acknowledge with nothing carried drops the interrupt
    p_ack_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && ack && !has_more) |=> !irq);

    // R8: a carried request with a nonzero period reopens a window
    p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && ack && has_more && !zero_period) |=> (st == CS_COUNT));
endmodule

// File: rtl/irq_coalesce_ctl.sv
`timescale 1ns/1ps
module irq_coalesce_ctl
    import coal_pkg::*;
#(
    parameter int          CYC_PER_US       = 100,
    parameter logic [7:0]  DELAY_REG_OFFSET = 8'h0C,
    parameter bit          CAP_PRESENT      = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr_en,
    input  logic [15:0] reg_wr_data,
    output logic [15:0] reg_rd_data,
    input  logic        cmpl_irq_req,
    input  logic        irq_ack,
    output logic        irq_out
);
    logic                us_tick;
    logic [PERIOD_W-1:0] period;

    coal_tick_div #(.CYC_PER_US(CYC_PER_US)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick)
    );

    coal_delay_reg #(
        .ADDR_W      (8),
        .REG_OFFSET  (DELAY_REG_OFFSET),
        .CAP_PRESENT (CAP_PRESENT)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .period  (period)
    );

    coal_window_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (us_tick),
        .req    (cmpl_irq_req),
        .ack    (irq_ack),
        .period (period),
        .irq    (irq_out)
    );

    // R1: the capability flag reads set whenever the word is addressed
    p_cap_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == DELAY_REG_OFFSET) |-> (reg_rd_data[CAP_BIT] == CAP_PRESENT));
endmodule

// File: tb/sim_irq_coalesce_ctl.sv
`timescale 1ns/1ps
module sim_irq_coalesce_ctl;
    localparam int         C   = 4;
    localparam logic [7:0] OFS = 8'h0C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = OFS;
    logic        wen = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        req = 1'b0;
    logic        ack = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    int exp_q[$];
    string tag_q[$];
    logic irq_prev = 1'b0;

    always #5 clk = ~clk;

    irq_coalesce_ctl #(.CYC_PER_US(C)) u0 (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (addr),
        .reg_wr_en   (wen),
        .reg_wr_data (wdata),
        .reg_rd_data (rdata),
        .cmpl_irq_req(req),
        .irq_ack     (ack),
        .irq_out     (irq)
    );

    always @(posedge clk) if (!rst) edge_n <= edge_n + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fire_at(input int k, input int n);
        return (k / C + 1) * C + (n - 1) * C;
    endfunction

    // scoreboard monitor: every rising edge of irq must match the queue head
    always @(negedge clk) begin
        int e;
        string t;
        if (!rst && irq && !irq_prev) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R6 unexpected interrupt edge", edge_n, -1);
            else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(edge_n == e, t, edge_n, e);
            end
        end
        irq_prev <= irq;
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wen = 1'b1; wdata = d;
        @(negedge clk);
        wen = 1'b0; addr = OFS;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == e, tag, rdata, e);
        addr = OFS;
    endtask

    // driver: request with expected fire edge pushed to the scoreboard
    task automatic req_win(input int n, input string tag);
        int k;
        @(negedge clk);
        req = 1'b1;
        k = edge_n + 1;
        exp_q.push_back(n == 0 ? k : fire_at(k, n));
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic extra_req();
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic ack_pulse(output int a);
        @(negedge clk);
        ack = 1'b1;
        a = edge_n + 1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int a;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk(rdata == 16'h8000, "R1 reset read", rdata, 16'h8000);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);

        // R2 field masking
        wr(OFS, 16'hFFFF);
        rd_chk(OFS, 16'hBFFF, "R2 write all ones");
        wr(OFS, 16'h4005);
        rd_chk(OFS, 16'h8005, "R2 reserved and cap ignored");

        // R3 decode
        wr(8'h10, 16'h0003);
        rd_chk(OFS, 16'h8005, "R3 foreign write ignored");
        rd_chk(8'h10, 16'h0000, "R3 foreign read zero");

        // R7 acknowledge while idle is ignored
        ack_pulse(a);
        chk(irq == 1'b0, "R7 idle ack", irq, 0);

        // R4 bypass
        wr(OFS, 16'h0000);
        req_win(0, "R4 bypass edge");
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R7 level held", irq, 1);
        ack_pulse(a);
        chk(irq == 1'b0, "R7 ack clears", irq, 0);

        // R5 / R6 window with absorbed requests
        wr(OFS, 16'h0003);
        req_win(3, "R5 R6 window 3us");
        extra_req();
        repeat (2) @(negedge clk);
        extra_req();
        extra_req();
        wait_irq(40);
        chk(irq == 1'b1, "R5 window fired", irq, 1);
        ack_pulse(a);
        chk(irq == 1'b0, "R6 single interrupt", irq, 0);
        repeat (20) @(negedge clk);
        chk(irq == 1'b0, "R6 no second interrupt", irq, 0);

        // R9 rewrite during a window
        wr(OFS, 16'h0005);
        req_win(5, "R9 old period kept");
        repeat (2) @(negedge clk);
        wr(OFS, 16'h0002);
        wait_irq(60);
        ack_pulse(a);
        req_win(2, "R9 new period next window");
        wait_irq(40);
        ack_pulse(a);

        // R8 carried request with nonzero period
        req_win(2, "R8 first window");
        wait_irq(40);
        extra_req();
        @(negedge clk);
        ack = 1'b1;
        a = edge_n + 1;
        exp_q.push_back(fire_at(a, 2));
        tag_q.push_back("R8 rearm window");
        @(negedge clk);
        ack = 1'b0;
        chk(irq == 1'b0, "R8 drop on rearm", irq, 0);
        wait_irq(40);
        chk(irq == 1'b1, "R8 rearm fired", irq, 1);
        ack_pulse(a);

        // R8 carried request with zero period
        wr(OFS, 16'h0000);
        req_win(0, "R8 bypass first");
        extra_req();
        ack_pulse(a);
        chk(irq == 1'b1, "R8 refire holds", irq, 1);
        ack_pulse(a);
        chk(irq == 1'b0, "R8 final release", irq, 0);

        // R10 largest period
        wr(OFS, 16'h3FFF);
        rd_chk(OFS, 16'hBFFF, "R10 max stored");
        req_win(16383, "R10 max window");
        wait_irq(70000);
        chk(irq == 1'b1, "R10 max fired", irq, 1);
        ack_pulse(a);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule